// File: doc/BRIEF.md
# Three-Axis Quadrature Position Decoder

This block turns three independent pairs of quadrature encoder signals into three signed 16-bit position counts. Each pair is first brought into the clock domain through a synchroniser. It is then sampled on a tick from a programmable divider. Each legal Gray-code step moves that axis count up or down by one. A leads B for counting up. An illegal jump, where both lines change between two samples, is dropped.

All three axes feed one shared event total. When the total since the last acknowledge reaches a programmable threshold, a sticky status flag sets. The interrupt pin is that flag gated by a mask bit. Software runs the block through a plain register strobe port with 16-bit registers. A write takes effect at the next clock edge. A read is combinational on the address. The block carries no streaming data, so there is no valid/ready handshake and no back-pressure. Every pin is plain control or status.

Top module: `quad3_decoder`

## Requirements
- R1: After reset the control register (byte offset 0) reads 0x0010, every count register and the divider register read 0, and `irq` is low.
- R2: With divider 0, each step in the order AB = 00, 10, 11, 01, 00 adds one to the axis count, and each step in the opposite order subtracts one. The new count is readable three clock cycles after the input change. The X, Y and Z counts are at byte offsets 2, 4 and 6.
- R3: A sample in which both A and B differ from the previous sample leaves the count unchanged.
- R4: Divider register bits [9:0] at offset 8 hold D. The encoder lines are compared only on every (D+1)-th clock, so a step that is undone before the next sample is not counted.
- R5: Control bits 10, 11 and 12 enable X, Y and Z. A disabled axis reads 0, counts nothing and adds no events. When the axis is enabled again it starts from 0.
- R6: The counts wrap in 16-bit two's complement: one reverse step from 0 reads 0xFFFF, and one forward step from 0xFFFF reads 0.
- R7: Control bits [9:3] hold a threshold T, where a value of 0 acts as 1. Status (control bit 2, read-only) sets once the number of decoded steps on enabled axes since the last acknowledge reaches T. Steps on several axes in the same sample each count. Status stays set until it is acknowledged.
- R8: A control write with bit 1 set clears the status and the event total, and any step in that same cycle is discarded. Bit 1 always reads 0.
- R9: `irq` is high exactly when status is set and mask bit 0 is 1. Status still sets while the mask is 0.
- R10: Writes to offsets 2, 4, 6 or any unmapped offset change nothing. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| enc_a | input | 3 | Encoder A lines, bit 0 is X, bit 1 is Y, bit 2 is Z |
| enc_b | input | 3 | Encoder B lines, bit 0 is X, bit 1 is Y, bit 2 is Z |
| irq | output | 1 | Interrupt, status gated by mask |

## Verification
An encoder edge passes through two synchroniser flops and then the count register. With divider 0, the count, the status flag and `irq` therefore change three edges after the input changes. With divider D this can stretch by up to D further cycles, until the next sampling tick. Register writes show on the read port one edge after the strobe, and reads have no delay. The reference model in the bench delays the encoder history by the same two samples and steps its divider phase on every edge. It then compares the read data at a rotating address, and `irq`, at every falling edge, so each result is checked in the exact cycle it falls due.

// File: rtl/quad3_pkg.sv
package quad3_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 4'h0;
  localparam int                OFS_AXIS0 = 2;
  localparam logic [ADDR_W-1:0] OFS_DIV   = 4'h8;

  localparam int CB_MASK   = 0;
  localparam int CB_ACK    = 1;
  localparam int CB_STAT   = 2;
  localparam int CB_THR_LO = 3;
  localparam int CB_EN_LO  = 10;

  localparam logic [REG_W-1:0] CTRL_RESET = 16'h0010;

  typedef enum logic [1:0] {
    MOVE_NONE = 2'd0,
    MOVE_UP   = 2'd1,
    MOVE_DOWN = 2'd2
  } move_e;
endpackage

// File: rtl/qd_sync.sv
module qd_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= din;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/qd_tick.sv
module qd_tick #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] phase;

  assign tick = (phase >= div_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase <= '0;
    else if (tick) phase <= '0;
    else           phase <= phase + DIV_W'(1);
  end

  // R4: after a tick a nonzero divider holds off the next one
  p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_val != '0) |=> (!tick || div_val == '0));
endmodule

// File: rtl/qd_axis.sv
module qd_axis
  import quad3_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic             a,
  input  logic             b,
  output logic [CNT_W-1:0] cnt,
  output logic             step
);
  logic [1:0] prev_ab;
  logic [1:0] cur_ab;
  move_e      move;

  assign cur_ab = {a, b};

  always_comb begin
    unique case ({prev_ab, cur_ab})
      4'b0010, 4'b1011, 4'b1101, 4'b0100: move = MOVE_UP;
      4'b0001, 4'b0111, 4'b1110, 4'b1000: move = MOVE_DOWN;
      default:                            move = MOVE_NONE;
    endcase
  end

  assign step = tick && en && (move != MOVE_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_ab <= 2'b00;
      cnt     <= '0;
    end else begin
      if (tick) prev_ab <= cur_ab;
      if (!en) begin
        cnt <= '0;
      end else if (tick) begin
        case (move)
          MOVE_UP:   cnt <= cnt + CNT_W'(1);
          MOVE_DOWN: cnt <= cnt - CNT_W'(1);
          default:   cnt <= cnt;
        endcase
      end
    end
  end

  // R5: a disabled axis holds zero
  p_off_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));
  // R2: an enabled axis moves by at most one per cycle
  p_unit_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1) ||
            cnt == $past(cnt) - CNT_W'(1)));
  // R4: no count change between ticks
  p_hold_no_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(cnt));
endmodule

// File: rtl/quad3_decoder.sv
module quad3_decoder
  import quad3_pkg::*;
#(
  parameter int NUM_AXES    = 3,
  parameter int CNT_W       = 16,
  parameter int DIV_W       = 10,
  parameter int THR_W       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [2:0]        enc_a,
  input  logic [2:0]        enc_b,
  output logic              irq
);
  localparam int EV_W  = THR_W + 1;
  localparam int EVS_W = EV_W + 1;
  localparam logic [EV_W-1:0] EV_MAX = '1;

  logic [NUM_AXES-1:0] en_q;
  logic [THR_W-1:0]    thr_q;
  logic                mask_q;
  logic                status_q;
  logic [DIV_W-1:0]    div_q;
  logic [EV_W-1:0]     ev_q;

  logic [2*NUM_AXES-1:0] sync_in, sync_out;
  logic [NUM_AXES-1:0]   step_v;
  logic [CNT_W-1:0]      cnt_v [NUM_AXES];
  logic                  tick;

  assign sync_in = {enc_b[NUM_AXES-1:0], enc_a[NUM_AXES-1:0]};

  qd_sync #(.W(2*NUM_AXES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(sync_in), .dout(sync_out));

  qd_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div_val(div_q), .tick(tick));

  for (genvar g = 0; g < NUM_AXES; g++) begin : g_axis
    qd_axis #(.CNT_W(CNT_W)) u_axis (
      .clk(clk), .rst_n(rst_n), .tick(tick), .en(en_q[g]),
      .a(sync_out[g]), .b(sync_out[NUM_AXES+g]),
      .cnt(cnt_v[g]), .step(step_v[g]));
  end

  logic             wr_ctrl, ack;
  logic [THR_W-1:0] thr_eff;
  logic [EVS_W-1:0] ev_sum;
  logic [EV_W-1:0]  ev_next;

  assign wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
  assign ack     = wr_ctrl && reg_wdata[CB_ACK];
  assign thr_eff = (thr_q == '0) ? THR_W'(1) : thr_q;
  assign ev_sum  = {1'b0, ev_q} + EVS_W'($countones(step_v));
  assign ev_next = ev_sum[EV_W] ? EV_MAX : ev_sum[EV_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= CTRL_RESET[CB_EN_LO +: NUM_AXES];
      thr_q  <= CTRL_RESET[CB_THR_LO +: THR_W];
      mask_q <= CTRL_RESET[CB_MASK];
      div_q  <= '0;
    end else if (reg_wr) begin
      if (reg_addr == OFS_CTRL) begin
        en_q   <= reg_wdata[CB_EN_LO +: NUM_AXES];
        thr_q  <= reg_wdata[CB_THR_LO +: THR_W];
        mask_q <= reg_wdata[CB_MASK];
      end
      if (reg_addr == OFS_DIV) div_q <= reg_wdata[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q     <= '0;
      status_q <= 1'b0;
    end else if (ack) begin
      ev_q     <= '0;
      status_q <= 1'b0;
    end else begin
      ev_q <= ev_next;
      if (ev_next >= EV_W'(thr_eff)) status_q <= 1'b1;
    end
  end

  assign irq = status_q & mask_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFS_CTRL) begin
      reg_rdata[CB_MASK]                = mask_q;
      reg_rdata[CB_STAT]                = status_q;
      reg_rdata[CB_THR_LO +: THR_W]     = thr_q;
      reg_rdata[CB_EN_LO +: NUM_AXES]   = en_q;
    end else if (reg_addr == OFS_DIV) begin
      reg_rdata[DIV_W-1:0] = div_q;
    end else begin
      for (int i = 0; i < NUM_AXES; i++) begin
        if (reg_addr == ADDR_W'(OFS_AXIS0 + 2*i) && en_q[i])
          reg_rdata = REG_W'(cnt_v[i]);
      end
    end
  end

  // R8: acknowledge empties status and event total
  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (!status_q && ev_q == '0));
  // R7: status is sticky until acknowledged
  p_status_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && !ack) |=> status_q);
  // R7: event total never falls without an acknowledge
  p_ev_monotonic_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> (ev_q >= $past(ev_q)));
endmodule

// File: tb/test_quad3_decoder.sv
module test_quad3_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int NAX = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [2:0]  enc_a = '0;
  logic [2:0]  enc_b = '0;
  logic        irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad3_decoder i_quad3_decoder (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .enc_a(enc_a), .enc_b(enc_b), .irq(irq));

  int    vectors = 0;
  int    misses = 0;
  string tag = "R1";
  bit    done = 1'b0;

  // behavioural reference model
  int m_cnt [NAX];
  int m_prev [NAX];
  int m_en [NAX];
  int m_ev, m_status, m_thr, m_mask, m_div, m_phase;
  int hist [$];

  function automatic int gpos(int ab);
    case (ab)
      0: return 0;
      2: return 1;
      3: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic m_reset();
    for (int i = 0; i < NAX; i++) begin
      m_cnt[i] = 0; m_prev[i] = 0; m_en[i] = 0;
    end
    m_ev = 0; m_status = 0; m_thr = 2; m_mask = 0; m_div = 0; m_phase = 0;
    hist.delete();
    hist.push_back(0);
    hist.push_back(0);
  endtask

  task automatic m_step();
    int seen, steps, thr_e;
    bit tk;
    seen = hist.pop_front();
    hist.push_back(int'({enc_b, enc_a}));
    tk = (m_phase >= m_div);
    m_phase = tk ? 0 : m_phase + 1;
    steps = 0;
    for (int i = 0; i < NAX; i++) begin
      int ab, d;
      ab = ((seen >> i) & 1) * 2 + ((seen >> (i + 3)) & 1);
      if (tk) begin
        d = (gpos(ab) - gpos(m_prev[i]) + 4) % 4;
        if (m_en[i] != 0) begin
          if (d == 1) begin m_cnt[i] = (m_cnt[i] + 1) & 16'hFFFF; steps++; end
          if (d == 3) begin m_cnt[i] = (m_cnt[i] + 65535) & 16'hFFFF; steps++; end
        end
        m_prev[i] = ab;
      end
      if (m_en[i] == 0) m_cnt[i] = 0;
    end
    m_ev = (m_ev + steps > 255) ? 255 : m_ev + steps;
    thr_e = (m_thr == 0) ? 1 : m_thr;
    if (m_ev >= thr_e) m_status = 1;
    if (reg_wr) begin
      if (reg_addr == 4'd0) begin
        if (reg_wdata[1]) begin m_ev = 0; m_status = 0; end
        for (int i = 0; i < NAX; i++) m_en[i] = reg_wdata[10 + i];
        m_thr = reg_wdata[9:3];
        m_mask = reg_wdata[0];
      end
      if (reg_addr == 4'd8) m_div = reg_wdata[9:0];
    end
  endtask

  function automatic int m_read(int a);
    case (a)
      0: return (m_en[2] << 12) | (m_en[1] << 11) | (m_en[0] << 10) |
                (m_thr << 3) | (m_status << 2) | m_mask;
      2, 4, 6: return (m_en[a/2 - 1] != 0) ? m_cnt[a/2 - 1] : 0;
      8: return m_div;
      default: return 0;
    endcase
  endfunction

  initial m_reset();

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else m_step();
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int exp_rd;
      exp_rd = m_read(int'(reg_addr));
      vectors++;
      if (int'(reg_rdata) != exp_rd) begin
        misses++;
        $display("FAIL %s addr=%0d rdata actual=%h expected=%h", tag,
                 reg_addr, reg_rdata, exp_rd[15:0]);
      end
      vectors++;
      if (irq != ((m_status != 0) && (m_mask != 0))) begin
        misses++;
        $display("FAIL %s irq actual=%0d expected=%0d", tag, irq,
                 m_status & m_mask);
      end
    end
  end

  // register port driver: pending write or rotating read address
  bit pend = 1'b0;
  int p_addr, p_data;
  int rot = 0;
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (pend) begin
      reg_wr = 1'b1; reg_addr = 4'(p_addr); reg_wdata = 16'(p_data);
      pend = 1'b0;
    end else begin
      reg_wr = 1'b0; reg_addr = 4'(rot * 2);
      rot = (rot + 1) % 6;
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    p_addr = a; p_data = d; pend = 1'b1;
    wait (pend == 1'b0);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  int epos [NAX] = '{0, 0, 0};

  task automatic drive_enc();
    for (int i = 0; i < NAX; i++) begin
      enc_a[i] = (epos[i] == 1 || epos[i] == 2);
      enc_b[i] = (epos[i] == 2 || epos[i] == 3);
    end
  endtask

  task automatic move(int msk, int dir, int gap);
    @(negedge clk);
    for (int i = 0; i < NAX; i++)
      if ((msk >> i) & 1) epos[i] = (epos[i] + dir + 4) % 4;
    drive_enc();
    idle(gap);
  endtask

  task automatic jump(int ax, int gap);
    @(negedge clk);
    epos[ax] = (epos[ax] + 2) % 4;
    drive_enc();
    idle(gap);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      misses++;
      $display("FAIL %s watchdog expired", tag);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    tag = "R1"; idle(12);

    tag = "R5";                      // X only, threshold 4, unmasked
    wr(0, 16'h0421);
    move(2, 1, 6); move(2, 1, 6);    // Y disabled: stays 0

    tag = "R2";
    for (int k = 0; k < 4; k++) move(1, 1, 6);
    for (int k = 0; k < 2; k++) move(1, -1, 6);

    tag = "R8";
    wr(0, 16'h0423); idle(8);

    tag = "R3";
    jump(0, 8); jump(0, 8);

    tag = "R7";                      // all axes, threshold 3
    wr(0, 16'h1C1B);
    move(7, 1, 8);                   // three events in one sample
    wr(0, 16'h1C03);                 // ack, threshold 0 acts as 1
    idle(4);
    move(4, 1, 8);

    tag = "R9";                      // masked, threshold 3
    wr(0, 16'h1C1A);
    move(7, -1, 8);
    wr(0, 16'h1C19); idle(8);

    tag = "R4";
    wr(8, 3); idle(4);
    move(1, 1, 10); move(2, -1, 10);
    move(1, 1, 1); move(1, -1, 12);  // short glitch
    wr(8, 0); idle(6);

    tag = "R6";
    wr(0, 16'h0001); idle(4);
    wr(0, 16'h0401); idle(4);
    move(1, -1, 6); move(1, 1, 6); move(1, -1, 6);

    tag = "R5";
    wr(0, 16'h0C01);
    move(2, 1, 6); move(2, 1, 6);
    wr(0, 16'h0401); idle(8);
    wr(0, 16'h0C01); idle(8);

    tag = "R10";
    wr(2, 16'h1234); wr(4, 16'h5678); wr(6, 16'h9ABC);
    wr(10, 16'hFFFF); wr(14, 16'hFFFF); idle(12);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule